// File: doc/BRIEF.md
# Video Output Level Selector

This block decides, on every pixel clock and for each of three colour channels, which level the output stage has to produce. It takes a blanking flag, a fast-blank flag from an on-screen display source, three one-bit display colour inputs, and register settings for brightness, display contrast and two grey-background enables. For each channel it produces a mode code and a digital level code in units of one brightness step above the infra-black level. It also tells the analog front end when to switch the main picture input over to its clamp reference.

The order of precedence is fixed. Blanking comes first, then fast blank, then the main picture. While fast blank is high, each channel shows either the brightness level or the brightness level plus the display contrast, according to its own display bit. One specific colour pattern can be replaced by a light or dark grey that is the same on all three channels. All outputs are registered, so they follow the inputs one clock later.

Top module: `vid_level_sel`

## Requirements
- R1: While reset is asserted, every channel mode is infra-black (code 0), every level is 0 and `clampSel` is 0.
- R2: If `blankIn` was high at a clock edge, every channel reports mode infra-black (0) with level 0 after that edge, whatever the other inputs are.
- R3: With `blankIn` and `fastBlankIn` both low, every channel reports mode video (3) with level `BLACK_OFS + brtCode`. BLACK_OFS defaults to 50 (0.4 V in 8 mV steps).
- R4: `clampSel` equals the value `fastBlankIn` had at the previous clock edge.
- R5: With fast blank high and blanking low, a channel whose display bit is 0 reports mode brightness (1) with level `BLACK_OFS + brtCode`. Channel k uses `osdIn[k]` and reports in `chMode[3k+2:3k]` and `chLevel[11k+10:11k]`.
- R6: Under the same conditions, a channel whose display bit is 1 reports mode display (2) with level `BLACK_OFS + brtCode + OSD_STEP*osdCont`. OSD_STEP defaults to 40 (320 mV).
- R7: With fast blank high, blanking low, `osdIn` = 3'b101 and `greyLightEn` = 1, all three channels report mode grey (4) with level `brt + A - (A>>2)`, where `brt` is the brightness level and `A = OSD_STEP*osdCont`.
- R8: Under the same conditions with `greyLightEn` = 0 and `greyDarkEn` = 1, all channels report grey with level `brt + (A>>2)`.
- R9: When both grey enables are set, the light grey level is used.
- R10: When both grey enables are clear, the pattern 3'b101 is mixed as ordinary display colours, with no grey.
- R11: Grey enables have no effect on any display pattern other than 3'b101.
- R12: An input change shows on the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| blankIn | input | 1 | Blanking flag, highest priority |
| fastBlankIn | input | 1 | Display fast-blank flag |
| osdIn | input | 3 | Display colour bits, bit k for channel k |
| brtCode | input | 8 | Brightness setting |
| osdCont | input | 4 | Display contrast setting |
| greyLightEn | input | 1 | Light grey background enable |
| greyDarkEn | input | 1 | Dark grey background enable |
| chMode | output | 9 | Per-channel mode, 3 bits each |
| chLevel | output | 33 | Per-channel level code, 11 bits each |
| clampSel | output | 1 | Switch main video input to its clamp reference |

## Verification
The bench applies blanking together with fast blank and the grey pattern to check that blanking wins. A design with the priorities swapped would show display or grey levels during blanking. It sets both grey enables to test the light-over-dark choice, and it applies the grey pattern with both enables clear. A wrong decoder would emit grey when it should mix normal colours, or pick the dark level. It also applies near-miss patterns with the enables set, which catches a pattern match that ignores one bit. The extreme brightness and contrast codes are used as well, to catch truncation of the level sum.

// File: rtl/vid_level_pkg.sv
package vid_level_pkg;
  typedef enum logic [2:0] {
    MODE_IBLK = 3'd0,
    MODE_BRT  = 3'd1,
    MODE_OSD  = 3'd2,
    MODE_VID  = 3'd3,
    MODE_GREY = 3'd4
  } chMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       blank;
    logic       osdOn;
    logic       greyLight;
    logic       greyDark;
    logic       clamp;
    logic [2:0] osdBits;
  } selStrobe_t;
endpackage

// File: rtl/vid_level_ctrl.sv
module vid_level_ctrl
  import vid_level_pkg::*;
#(
  parameter logic [2:0] GREY_PAT = 3'b101
) (
  input  logic       blankIn,
  input  logic       fastBlankIn,
  input  logic [2:0] osdIn,
  input  logic       greyLightEn,
  input  logic       greyDarkEn,
  output selStrobe_t strobe
);
  logic greyHit;

  always_comb begin
    greyHit          = fastBlankIn && (osdIn == GREY_PAT) && (greyLightEn || greyDarkEn);
    strobe.blank     = blankIn;
    strobe.osdOn     = fastBlankIn && !blankIn;
    strobe.greyLight = greyHit && !blankIn && greyLightEn;
    strobe.greyDark  = greyHit && !blankIn && !greyLightEn && greyDarkEn;
    strobe.clamp     = fastBlankIn;
    strobe.osdBits   = osdIn;
  end
endmodule

// File: rtl/vid_level_dp.sv
module vid_level_dp
  import vid_level_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int BRT_W     = 8,
  parameter int OSDC_W    = 4,
  parameter int LVL_W     = 11,
  parameter int BLACK_OFS = 50,
  parameter int OSD_STEP  = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  selStrobe_t              strobe,
  input  logic [BRT_W-1:0]        brtCode,
  input  logic [OSDC_W-1:0]       osdCont,
  output logic [3*NUM_CH-1:0]     chMode,
  output logic [LVL_W*NUM_CH-1:0] chLevel,
  output logic                    clampSel
);
  logic [LVL_W-1:0] brtLvl, osdAdd, osdQuarter, lightLvl, darkLvl, osdLvl;

  always_comb begin
    brtLvl     = LVL_W'(BLACK_OFS) + LVL_W'(brtCode);
    osdAdd     = LVL_W'(osdCont) * LVL_W'(OSD_STEP);
    osdQuarter = osdAdd >> 2;
    osdLvl     = brtLvl + osdAdd;
    lightLvl   = brtLvl + osdAdd - osdQuarter;
    darkLvl    = brtLvl + osdQuarter;
  end

  always_ff @(posedge clk) begin
    if (!rstN) clampSel <= 1'b0;
    else       clampSel <= strobe.clamp;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    chMode_e          nextMode;
    logic [LVL_W-1:0] nextLevel;

    always_comb begin
      if (strobe.blank) begin
        nextMode  = MODE_IBLK;
        nextLevel = '0;
      end else if (strobe.greyLight) begin
        nextMode  = MODE_GREY;
        nextLevel = lightLvl;
      end else if (strobe.greyDark) begin
        nextMode  = MODE_GREY;
        nextLevel = darkLvl;
      end else if (strobe.osdOn && strobe.osdBits[ch]) begin
        nextMode  = MODE_OSD;
        nextLevel = osdLvl;
      end else if (strobe.osdOn) begin
        nextMode  = MODE_BRT;
        nextLevel = brtLvl;
      end else begin
        nextMode  = MODE_VID;
        nextLevel = brtLvl;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chMode[3*ch +: 3]         <= MODE_IBLK;
        chLevel[LVL_W*ch +: LVL_W] <= '0;
      end else begin
        chMode[3*ch +: 3]         <= nextMode;
        chLevel[LVL_W*ch +: LVL_W] <= nextLevel;
      end
    end
  end
endmodule

// File: rtl/vid_level_sel.sv
module vid_level_sel
  import vid_level_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int BRT_W     = 8,
  parameter int OSDC_W    = 4,
  parameter int LVL_W     = 11,
  parameter int BLACK_OFS = 50,
  parameter int OSD_STEP  = 40
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    blankIn,
  input  logic                    fastBlankIn,
  input  logic [NUM_CH-1:0]       osdIn,
  input  logic [BRT_W-1:0]        brtCode,
  input  logic [OSDC_W-1:0]       osdCont,
  input  logic                    greyLightEn,
  input  logic                    greyDarkEn,
  output logic [3*NUM_CH-1:0]     chMode,
  output logic [LVL_W*NUM_CH-1:0] chLevel,
  output logic                    clampSel
);
  selStrobe_t strobe;

  vid_level_ctrl u_ctrl (
    .blankIn     (blankIn),
    .fastBlankIn (fastBlankIn),
    .osdIn       (osdIn),
    .greyLightEn (greyLightEn),
    .greyDarkEn  (greyDarkEn),
    .strobe      (strobe)
  );

  vid_level_dp #(
    .NUM_CH(NUM_CH), .BRT_W(BRT_W), .OSDC_W(OSDC_W), .LVL_W(LVL_W),
    .BLACK_OFS(BLACK_OFS), .OSD_STEP(OSD_STEP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .brtCode  (brtCode),
    .osdCont  (osdCont),
    .chMode   (chMode),
    .chLevel  (chLevel),
    .clampSel (clampSel)
  );
endmodule

// File: rtl/vid_level_sel_chk.sv
module vid_level_sel_chk #(
  parameter int LVL_W     = 11,
  parameter int BLACK_OFS = 50
) (
  input logic               clk,
  input logic               rstN,
  input logic               blankIn,
  input logic               fastBlankIn,
  input logic [8:0]         chMode,
  input logic [3*LVL_W-1:0] chLevel,
  input logic               clampSel
);
  // R2: blanking forces infra-black on all channels
  a_r2_blank_iblk: assert property (@(posedge clk) disable iff (!rstN)
    blankIn |=> (chMode == 9'd0 && chLevel == '0));

  // R4: clamp select follows fast blank
  a_r4_clamp_on: assert property (@(posedge clk) disable iff (!rstN)
    fastBlankIn |=> clampSel);
  a_r4_clamp_off: assert property (@(posedge clk) disable iff (!rstN)
    !fastBlankIn |=> !clampSel);

  // R3: main picture selected when neither flag is set
  a_r3_video_mode: assert property (@(posedge clk) disable iff (!rstN)
    (!blankIn && !fastBlankIn) |=> (chMode == {3'd3, 3'd3, 3'd3}));

  // R5: never below black outside blanking
  a_r5_black_floor: assert property (@(posedge clk) disable iff (!rstN)
    !blankIn |=> (chLevel[LVL_W-1:0] >= LVL_W'(BLACK_OFS)));

  // R7: grey is applied to all channels alike
  a_r7_grey_uniform: assert property (@(posedge clk) disable iff (!rstN)
    (chMode[2:0] == 3'd4) |-> (chMode[5:3] == 3'd4 && chMode[8:6] == 3'd4 &&
      chLevel[LVL_W-1:0] == chLevel[2*LVL_W-1:LVL_W] &&
      chLevel[LVL_W-1:0] == chLevel[3*LVL_W-1:2*LVL_W]));
endmodule

bind vid_level_sel vid_level_sel_chk #(.LVL_W(LVL_W), .BLACK_OFS(BLACK_OFS)) u_chk (
  .clk(clk), .rstN(rstN), .blankIn(blankIn), .fastBlankIn(fastBlankIn),
  .chMode(chMode), .chLevel(chLevel), .clampSel(clampSel)
);

// File: tb/vid_level_sel_tb.sv
module vid_level_sel_tb_top;
  localparam int LVL_W = 11;
  localparam int BLK   = 50;
  localparam int STEP  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blankIn = 1'b0, fastBlankIn = 1'b0, greyLightEn = 1'b0, greyDarkEn = 1'b0;
  logic [2:0] osdIn = 3'b000;
  logic [7:0] brtCode = 8'd0;
  logic [3:0] osdCont = 4'd0;
  logic [8:0] chMode;
  logic [3*LVL_W-1:0] chLevel;
  logic clampSel;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  vid_level_sel dut_i (
    .clk(clk), .rstN(rstN), .blankIn(blankIn), .fastBlankIn(fastBlankIn),
    .osdIn(osdIn), .brtCode(brtCode), .osdCont(osdCont),
    .greyLightEn(greyLightEn), .greyDarkEn(greyDarkEn),
    .chMode(chMode), .chLevel(chLevel), .clampSel(clampSel)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int modeOf(int ch);
    return int'(chMode[3*ch +: 3]);
  endfunction
  function automatic int lvlOf(int ch);
    return int'(chLevel[LVL_W*ch +: LVL_W]);
  endfunction

  task automatic drive(input logic b, input logic f, input logic [2:0] o,
                       input int brt, input int oc, input logic le, input logic de);
    @(negedge clk);
    blankIn = b; fastBlankIn = f; osdIn = o;
    brtCode = 8'(brt); osdCont = 4'(oc); greyLightEn = le; greyDarkEn = de;
    @(posedge clk); #1;
  endtask

  task automatic checkAll(input string req, input int m, input int l);
    for (int ch = 0; ch < 3; ch++) begin
      chk(req, modeOf(ch), m);
      chk(req, lvlOf(ch), l);
    end
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1", 0, 0);
    chk("R1 clamp", int'(clampSel), 0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tBlank();
    drive(1, 1, 3'b101, 200, 15, 1, 1);
    checkAll("R2", 0, 0);
    chk("R4 clamp under blank", int'(clampSel), 1);
  endtask

  task automatic tVideo();
    drive(0, 0, 3'b111, 0, 9, 1, 0);
    checkAll("R3 min", 3, BLK);
    chk("R4 clamp off", int'(clampSel), 0);
    drive(0, 0, 3'b000, 255, 0, 0, 0);
    checkAll("R3 max", 3, BLK + 255);
  endtask

  task automatic tOsdMix();
    drive(0, 1, 3'b110, 100, 7, 0, 0);
    chk("R5 ch0", modeOf(0), 1);  chk("R5 ch0 lvl", lvlOf(0), BLK + 100);
    chk("R6 ch1", modeOf(1), 2);  chk("R6 ch1 lvl", lvlOf(1), BLK + 100 + STEP * 7);
    chk("R6 ch2", modeOf(2), 2);  chk("R6 ch2 lvl", lvlOf(2), BLK + 100 + STEP * 7);
    chk("R4 clamp on", int'(clampSel), 1);
    drive(0, 1, 3'b111, 255, 15, 0, 0);
    checkAll("R6 max", 2, BLK + 255 + STEP * 15);
  endtask

  task automatic tGrey();
    int a;
    a = STEP * 15;
    drive(0, 1, 3'b101, 100, 15, 1, 0);
    checkAll("R7", 4, BLK + 100 + a - a / 4);
    drive(0, 1, 3'b101, 100, 15, 0, 1);
    checkAll("R8", 4, BLK + 100 + a / 4);
    drive(0, 1, 3'b101, 100, 15, 1, 1);
    checkAll("R9", 4, BLK + 100 + a - a / 4);
    drive(0, 1, 3'b101, 100, 15, 0, 0);
    chk("R10 ch0", modeOf(0), 2); chk("R10 ch1", modeOf(1), 1); chk("R10 ch2", modeOf(2), 2);
    chk("R10 ch1 lvl", lvlOf(1), BLK + 100);
  endtask

  task automatic tNearMiss();
    drive(0, 1, 3'b100, 20, 5, 1, 1);
    chk("R11 ch0", modeOf(0), 1); chk("R11 ch1", modeOf(1), 1); chk("R11 ch2", modeOf(2), 2);
    chk("R11 ch2 lvl", lvlOf(2), BLK + 20 + STEP * 5);
    drive(0, 1, 3'b111, 20, 5, 1, 1);
    checkAll("R11 all", 2, BLK + 20 + STEP * 5);
    drive(0, 0, 3'b101, 20, 5, 1, 1);
    checkAll("R11 no fb", 3, BLK + 20);
  endtask

  task automatic tLatency();
    drive(0, 0, 3'b000, 30, 0, 0, 0);
    @(negedge clk);
    blankIn = 1'b1;
    #2;
    chk("R12 hold mode", modeOf(0), 3);
    chk("R12 hold lvl", lvlOf(0), BLK + 30);
    @(posedge clk); #1;
    chk("R12 update", modeOf(0), 0);
  endtask

  initial begin
    fork
      begin
        tReset();
        tBlank();
        tVideo();
        tOsdMix();
        tGrey();
        tNearMiss();
        tLatency();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule